// File: doc/BRIEF.md
# Completion Interrupt Moderator

This block sits between a DMA engine and its interrupt cause logic, one copy per transfer direction. It takes single-cycle completion pulses and turns them into fewer, later done pulses. When a completion arrives and moderation is switched on, the block enters a holding state and starts two timers. The burst timer limits how long the first pending completion can wait. The idle timer restarts on every new completion and expires once the stream has been quiet for the programmed gap. The first timer to expire releases one done pulse that covers every completion gathered so far, and both timers go back to zero.

Each timer has a control word and a threshold word, written through a small write-only port. A timer counts either core clock cycles or cycles on which an external microsecond tick is high. Software reprograms a timer by writing clear, then the threshold, then the enable and tick-select bits. With both timers disabled the block is transparent: each completion becomes a done pulse on the next cycle. A system uses one instance for receive and one for transmit.

Top module: `irqmod_unit`

States and transitions: `ST_IDLE` (nothing pending) and `ST_HOLD` (completions pending). PASS: `ST_IDLE` → `ST_IDLE` with a done pulse, when a completion arrives and both timers are disabled. ARM: `ST_IDLE` → `ST_HOLD` on a completion while at least one timer is enabled. WAIT: `ST_HOLD` → `ST_HOLD` while no timer expires. FIRE: `ST_HOLD` → `ST_IDLE` with a done pulse, when a timer expires. FLUSH: `ST_HOLD` → `ST_IDLE` with a done pulse, when both timers have become disabled.

## Requirements
- R1: After reset `done_o` is low, both timers are disabled with tick select off and thresholds zero, and the unit is in `ST_IDLE`.
- R2: While both enable bits are low, every cycle with `cmpl_i` high gives `done_o` high in the next cycle and in no other cycle.
- R3: A completion in `ST_IDLE` with at least one timer enabled moves the unit to `ST_HOLD` with no done pulse; completions arriving during `ST_HOLD` produce no pulse of their own and are covered by the next release.
- R4: The burst timer (address 0 control, address 1 threshold) starts at zero on the ARM cycle and advances once per step; when it reaches its threshold T, `done_o` rises. In clock mode with no other release, `done_o` is high exactly T cycles after the ARM edge.
- R5: The idle timer (address 2 control, address 3 threshold) returns to zero on every cycle with `cmpl_i` high while in `ST_HOLD` and does not advance in that cycle; it releases once it has advanced T times with no completion in between.
- R6: The first timer to expire produces a single-cycle `done_o` pulse, returns the unit to `ST_IDLE` and resets both timers to zero.
- R7: Control bit 2 selects tick mode: the timer then advances only on cycles where `tick_i` is high; with bit 2 low it advances every cycle.
- R8: An enabled timer with threshold zero never advances and never expires.
- R9: A control write with bit 0 set clears that timer: it is disabled, tick select is cleared and its count returns to zero. If both timers are disabled while in `ST_HOLD`, the next cycle shows a done pulse and the unit returns to `ST_IDLE` (FLUSH).
- R10: A control write with bit 0 low loads the enable from bit 1 and tick select from bit 2; writes take effect at the clock edge and act on timing from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_i | input | 1 | Completion event pulse from the DMA engine |
| tick_i | input | 1 | External microsecond tick, one cycle high per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: bit 0 picks threshold over control, bit 1 picks the idle timer over the burst timer |
| wr_data_i | input | TW | Write data: control bits 0 clear, 1 enable, 2 tick select, or a threshold |
| done_o | output | 1 | Moderated done interrupt pulse |

## Verification
Completions are applied as isolated pulses, as back-to-back runs, and as trains spaced closer and farther apart than the idle gap. The isolated pulse separates pass-through from a held release and shows the burst latency exactly; the back-to-back run shows merging and that the idle timer keeps restarting so the burst timer must win; spaced trains with both timers on decide which of the two expires first. Tick-driven runs, a zero threshold and a clear written in the middle of a hold probe the step source, the never-expire case and the flush path.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } mod_state_e;

    // control word bit positions
    localparam int CTL_CLR = 0;
    localparam int CTL_EN  = 1;
    localparam int CTL_EXT = 2;

    // timer index, also bit 1 of the register address
    localparam int TMR_BURST = 0;
    localparam int TMR_IDLE  = 1;

endpackage

// File: rtl/irqmod_cfg.sv
module irqmod_cfg
    import irqmod_pkg::*;
#(
    parameter int TW   = 16,
    parameter int NTMR = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [$clog2(NTMR):0]   wr_addr_i,
    input  logic [TW-1:0]           wr_data_i,
    output logic [NTMR-1:0]         en_o,
    output logic [NTMR-1:0]         ext_o,
    output logic [NTMR-1:0]         clr_o,
    output logic [NTMR-1:0][TW-1:0] thr_o
);

    localparam int IW = $clog2(NTMR);

    for (genvar k = 0; k < NTMR; k++) begin : g_reg
        logic hit_ctl;
        logic hit_thr;

        assign hit_ctl = wr_en_i && (wr_addr_i[IW:1] == IW'(k)) && !wr_addr_i[0];
        assign hit_thr = wr_en_i && (wr_addr_i[IW:1] == IW'(k)) &&  wr_addr_i[0];
        assign clr_o[k] = hit_ctl && wr_data_i[CTL_CLR];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_o[k]  <= 1'b0;
                ext_o[k] <= 1'b0;
                thr_o[k] <= '0;
            end else begin
                if (hit_ctl) begin
                    if (wr_data_i[CTL_CLR]) begin
                        en_o[k]  <= 1'b0;
                        ext_o[k] <= 1'b0;
                    end else begin
                        en_o[k]  <= wr_data_i[CTL_EN];
                        ext_o[k] <= wr_data_i[CTL_EXT];
                    end
                end
                if (hit_thr) begin
                    thr_o[k] <= wr_data_i;
                end
            end
        end
    end

endmodule

// File: rtl/irqmod_counter.sv
module irqmod_counter #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          en_i,
    input  logic          ext_i,
    input  logic          tick_i,
    input  logic [TW-1:0] thr_i,
    input  logic          restart_i,
    input  logic          zero_i,
    output logic          fire_o
);

    logic [TW-1:0] cnt_q;
    logic [TW:0]   cnt_inc;
    logic          step;
    logic          live;

    assign step    = ext_i ? tick_i : 1'b1;
    assign live    = run_i && en_i && (thr_i != '0) && step;
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign fire_o  = live && !restart_i && (cnt_inc >= {1'b0, thr_i});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (zero_i || restart_i || !run_i) begin
            cnt_q <= '0;
        end else if (live) begin
            cnt_q <= cnt_inc[TW-1:0];
        end
    end

endmodule

// File: rtl/irqmod_unit.sv
module irqmod_unit
    import irqmod_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmpl_i,
    input  logic          tick_i,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_addr_i,
    input  logic [TW-1:0] wr_data_i,
    output logic          done_o
);

    localparam int NTMR = 2;

    mod_state_e             state_q, state_d;
    logic                   emit;
    logic [NTMR-1:0]        en_w, ext_w, clr_w, fire_w;
    logic [NTMR-1:0][TW-1:0] thr_w;
    logic                   hold_w, active_w, fire_any_w, zero_w;

    irqmod_cfg #(.TW(TW), .NTMR(NTMR)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .en_o      (en_w),
        .ext_o     (ext_w),
        .clr_o     (clr_w),
        .thr_o     (thr_w)
    );

    assign hold_w     = (state_q == ST_HOLD);
    assign active_w   = |en_w;
    assign fire_any_w = |fire_w;
    assign zero_w     = hold_w && (!active_w || fire_any_w);

    for (genvar k = 0; k < NTMR; k++) begin : g_tmr
        irqmod_counter #(.TW(TW)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (hold_w),
            .en_i      (en_w[k]),
            .ext_i     (ext_w[k]),
            .tick_i    (tick_i),
            .thr_i     (thr_w[k]),
            .restart_i ((k == TMR_IDLE) ? cmpl_i : 1'b0),
            .zero_i    (zero_w || clr_w[k]),
            .fire_o    (fire_w[k])
        );
    end

    // next state and release decision
    always_comb begin
        state_d = state_q;
        emit    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmpl_i) begin
                    if (active_w) state_d = ST_HOLD;   // ARM
                    else          emit    = 1'b1;      // PASS
                end
            end
            ST_HOLD: begin
                if (!active_w) begin                   // FLUSH
                    emit    = 1'b1;
                    state_d = ST_IDLE;
                end else if (fire_any_w) begin         // FIRE
                    emit    = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= emit;
    end

endmodule

// File: rtl/irqmod_chk.sv
module irqmod_chk (
    input logic clk,
    input logic rst_n,
    input logic cmpl_i,
    input logic done_o,
    input logic hold,
    input logic active,
    input logic fire_any
);

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !active && cmpl_i) |=> done_o);

    // R3
    arm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && active && cmpl_i) |=> (hold && !done_o));

    // R3
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !cmpl_i) |=> !done_o);

    // R6
    fire_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && fire_any) |=> (done_o && !hold));

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !active) |=> (done_o && !hold));

    // R6
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && active && !fire_any) |=> (hold && !done_o));

endmodule

bind irqmod_unit irqmod_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmpl_i   (cmpl_i),
    .done_o   (done_o),
    .hold     (hold_w),
    .active   (active_w),
    .fire_any (fire_any_w)
);

// File: tb/sim_irqmod_unit.sv
module sim_irqmod_unit;

    localparam int CLK_PERIOD = 10;
    localparam int TW         = 16;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmpl_i = 1'b0;
    logic          tick_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [1:0]    wr_addr_i = '0;
    logic [TW-1:0] wr_data_i = '0;
    logic          done_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    string req = "R1";
    bit    tick_on = 1'b0;
    int    tick_div = 0;

    // reference model state
    bit m_hold, m_done;
    bit m_en[2], m_ext[2];
    int m_thr[2], m_cnt[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    irqmod_unit #(.TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmpl_i(cmpl_i), .tick_i(tick_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .done_o(done_o)
    );

    // behavioural model, index 0 = burst, 1 = idle
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold = 0; m_done = 0;
            for (int k = 0; k < 2; k++) begin
                m_en[k] = 0; m_ext[k] = 0; m_thr[k] = 0; m_cnt[k] = 0;
            end
        end else begin
            bit act, nd, fire;
            bit stp[2];
            act = m_en[0] || m_en[1];
            nd = 0;
            if (!m_hold) begin
                if (cmpl_i) begin
                    if (act) begin m_hold = 1; m_cnt[0] = 0; m_cnt[1] = 0; end
                    else nd = 1;
                end
            end else begin
                fire = 0;
                for (int k = 0; k < 2; k++) begin
                    stp[k] = m_en[k] && (m_thr[k] != 0) && (!m_ext[k] || tick_i);
                    if (k == 1 && cmpl_i) stp[k] = 0;
                    if (stp[k] && (m_cnt[k] + 1 >= m_thr[k])) fire = 1;
                end
                if (!act || fire) begin
                    nd = 1; m_hold = 0; m_cnt[0] = 0; m_cnt[1] = 0;
                end else begin
                    if (stp[0]) m_cnt[0]++;
                    if (cmpl_i) m_cnt[1] = 0;
                    else if (stp[1]) m_cnt[1]++;
                end
            end
            if (wr_en_i) begin
                int k;
                k = wr_addr_i[1];
                if (wr_addr_i[0]) m_thr[k] = int'(wr_data_i);
                else if (wr_data_i[0]) begin m_en[k] = 0; m_ext[k] = 0; m_cnt[k] = 0; end
                else begin m_en[k] = wr_data_i[1]; m_ext[k] = wr_data_i[2]; end
            end
            m_done = nd;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (done_o !== m_done) begin
                n_bad++;
                $display("FAIL %s t=%0t done_o actual=%0b expected=%0b", req, $time, done_o, m_done);
            end
        end
    end

    // external tick generator, one high cycle every 5
    always @(negedge clk) begin
        if (tick_on) begin
            tick_div = (tick_div == 4) ? 0 : tick_div + 1;
            tick_i <= (tick_div == 0);
        end else begin
            tick_div = 0;
            tick_i <= 1'b0;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en_i <= 1'b1; wr_addr_i <= a; wr_data_i <= TW'(d);
        @(negedge clk);
        wr_en_i <= 1'b0;
    endtask

    task automatic pulse(input int gap);
        @(negedge clk);
        cmpl_i <= 1'b1;
        @(negedge clk);
        cmpl_i <= 1'b0;
        idle(gap);
    endtask

    task automatic burst_run(input int n);
        @(negedge clk);
        cmpl_i <= 1'b1;
        idle(n);
        cmpl_i <= 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n <= 1'b1;
        @(negedge clk);
        // R1: reset state at the port
        n_cmp++;
        if (done_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 done_o after reset actual=%0b expected=0", done_o);
        end
        idle(2);

        req = "R2";              // pass-through with timers disabled
        pulse(0); pulse(2); burst_run(4); idle(3);

        req = "R4";              // burst threshold 4 in clock mode
        wr(2'd0, 1); wr(2'd1, 4); wr(2'd0, 2);
        pulse(10);
        req = "R3";              // merging while held, idle restarts irrelevant
        burst_run(9); idle(6);
        pulse(1); pulse(8);

        req = "R5";              // idle timer alone, threshold 3
        wr(2'd0, 1); wr(2'd2, 1); wr(2'd3, 3); wr(2'd2, 2);
        pulse(1); pulse(1); pulse(1); idle(8);
        pulse(5);

        req = "R6";              // both timers, spaced completions: burst wins
        wr(2'd1, 6); wr(2'd0, 2);
        for (int i = 0; i < 6; i++) pulse(1);
        idle(6);
        pulse(10);               // quiet: idle timer wins

        req = "R7";              // tick mode on the burst timer
        wr(2'd2, 1); wr(2'd1, 2); wr(2'd0, 6);
        tick_on = 1'b1;
        pulse(20); pulse(3); pulse(20);
        tick_on = 1'b0;
        idle(2);

        req = "R8";              // zero threshold never releases
        wr(2'd0, 1); wr(2'd1, 0); wr(2'd0, 2);
        pulse(25);
        req = "R9";              // clear during hold flushes
        wr(2'd0, 1); idle(4);
        pulse(3);

        req = "R10";             // enable low with clear low disables; ext bit alone
        wr(2'd0, 2); wr(2'd1, 3);
        pulse(2); wr(2'd0, 4); idle(3);
        pulse(3);
        wr(2'd2, 6); wr(2'd3, 1);
        tick_on = 1'b1;
        pulse(12);
        tick_on = 1'b0;
        idle(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired in %s", req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule